// File: doc/BRIEF.md
# Serial Port with Per-Character Receive Throttling

This block is an 8N1 asynchronous serial port for a small processor. All bit timing comes from a 1 microsecond tick, which is derived from the system clock. A programmable half-bit count then divides that tick. One bit lasts two half-bits. A count of 4 gives 8 us per bit. That is roughly 8.5 % away from 115200 baud, and it is used as is. The processor reaches the port through a small register interface. It writes a byte to send and reads the byte received. It can also read a status byte and read or write the half-bit count.

Each port has an interrupt line. One line is raised when a character has gone out. The other is raised when a character has arrived. The transmitter waits while the clear-to-send input is low. It drives request-to-send while it holds or sends a byte.

The receive side sends a ready-for-data signal to the far end. That signal falls as soon as a start bit is seen. It rises again only when the processor reads the received byte. A fast sender is therefore held to one character for each processor read.

Top module: `uart_dtr`

## Requirements
- R1: TXD idles high. Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit.
- R2: A bit lasts 2 × N ticks of CLK_PER_TICK clocks, where N is the half-bit count register at address 2. N = 0 acts as N = 1, and the register still reads back 0.
- R3: `dtr` goes low within four clocks of a falling edge on `rxd` that begins a character.
- R4: `dtr` rises only on a read of the data register (address 0) while the receiver is idle, or when a start bit is rejected with no unread byte. A received byte leaves `dtr` low until that read.
- R5: A received byte appears at the data register (address 0). It sets status bit 0 (byte waiting) and `irq_rx`. A data read clears both. A status read (address 1) clears nothing.
- R6: While `cts` is low, no frame starts and `rts` stays high as long as a byte is waiting. Raising `cts` releases the frame.
- R7: `irq_tx` (status bit 3) is set when a stop bit has finished. Any write to the data register clears it.
- R8: A start bit that arrives while a byte is still unread sets the overrun flag (status bit 2). The new byte replaces the old one. A data read clears the flag.
- R9: After reset, `txd`=1, `dtr`=1, `rts`=0, both interrupts are 0, the half-bit count is 4, and status reads 0x02 (bit 1 = transmitter can accept a byte).
- R10: A low pulse on `rxd` that has ended by the half-bit check delivers no byte. It leaves `dtr` high when no byte is waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 data, 1 status, 2 half-bit count |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; carries the read side effects |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| irq_tx_o | output | 1 | Character-sent interrupt |
| irq_rx_o | output | 1 | Character-received interrupt |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| rts_o | output | 1 | Request to send, high while a byte is held or being sent |
| cts_i | input | 1 | Clear to send, high permits a new frame |
| dtr_o | output | 1 | Ready for data, high invites the next character |

## Verification
The hardest case to reach is the overrun. A second character must start while the first is still unread. This only happens if the far end ignores the throttle signal. The stimulus therefore drives two frames back to back on `rxd` without reading in between. It then checks the overrun flag and the replaced byte, and checks that `dtr` stayed low the whole time. The rejected start bit is also hard to reach: a pulse of only a few clocks must end before the half-bit confirmation point.

// File: rtl/uart_dtr_pkg.sv
package uart_dtr_pkg;
    localparam int HALF_W = 8;
    localparam int DATA_W = 8;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_HALF = 2'd2;

    localparam int ST_RX_FULL  = 0;
    localparam int ST_TX_READY = 1;
    localparam int ST_OVERRUN  = 2;
    localparam int ST_IRQ_TX   = 3;
    localparam int ST_IRQ_RX   = 4;

    typedef enum logic {TX_IDLE, TX_RUN} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_state_e;
endpackage

// File: rtl/uart_dtr_tick.sv
module uart_dtr_tick #(
    parameter int CLK_PER_TICK = 250
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == LAST);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_dtr_halftimer.sv
module uart_dtr_halftimer
    import uart_dtr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              restart_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              evt_o
);
    logic [HALF_W-1:0] cnt_d, cnt_q;

    always_comb begin
        evt_o = 1'b0;
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (cnt_q >= half_i - 1'b1) begin
                cnt_d = '0;
                evt_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_dtr_tx.sv
module uart_dtr_tx
    import uart_dtr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [HALF_W-1:0] half_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              cts_i,
    output logic              txd_o,
    output logic              ready_o,
    output logic              busy_o,
    output logic              done_o
);
    typedef struct packed {
        tx_state_e         st;
        logic [DATA_W-1:0] hold;
        logic              full;
        logic [DATA_W:0]   sh;
        logic [3:0]        bitn;
        logic              phase;
        logic              txd;
    } tx_regs_t;

    tx_regs_t q, d;
    logic restart, half_evt;

    uart_dtr_halftimer u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .restart_i (restart),
        .half_i    (half_i),
        .evt_o     (half_evt)
    );

    always_comb begin
        d       = q;
        done_o  = 1'b0;
        restart = 1'b0;
        if (load_i && !q.full) begin
            d.hold = data_i;
            d.full = 1'b1;
        end
        case (q.st)
            TX_IDLE: begin
                if (q.full && cts_i && tick_i) begin
                    d.st    = TX_RUN;
                    d.sh    = {1'b1, q.hold};
                    d.txd   = 1'b0;
                    d.bitn  = '0;
                    d.phase = 1'b0;
                    d.full  = 1'b0;
                    restart = 1'b1;
                end
            end
            default: begin
                if (half_evt) begin
                    if (!q.phase) begin
                        d.phase = 1'b1;
                    end else begin
                        d.phase = 1'b0;
                        if (q.bitn == 4'd9) begin
                            d.st   = TX_IDLE;
                            d.txd  = 1'b1;
                            done_o = 1'b1;
                        end else begin
                            d.bitn = q.bitn + 4'd1;
                            d.txd  = q.sh[0];
                            d.sh   = {1'b1, q.sh[DATA_W:1]};
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.st   <= TX_IDLE;
            q.txd  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd_o   = q.txd;
    assign ready_o = !q.full;
    assign busy_o  = (q.st == TX_RUN);

    p_cts_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == TX_IDLE && !cts_i) |=> (q.st == TX_IDLE));
    p_idle_line_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.st == TX_IDLE) |-> txd_o);
endmodule

// File: rtl/uart_dtr_rx.sv
module uart_dtr_rx
    import uart_dtr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [HALF_W-1:0] half_i,
    input  logic              rxd_i,
    output logic              start_o,
    output logic              abort_o,
    output logic              done_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              s1;
        logic              s2;
        rx_state_e         st;
        logic [DATA_W-1:0] sh;
        logic [3:0]        bitn;
        logic              phase;
    } rx_regs_t;

    rx_regs_t q, d;
    logic restart, half_evt;

    uart_dtr_halftimer u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .restart_i (restart),
        .half_i    (half_i),
        .evt_o     (half_evt)
    );

    always_comb begin
        d       = q;
        d.s1    = rxd_i;
        d.s2    = q.s1;
        start_o = 1'b0;
        abort_o = 1'b0;
        done_o  = 1'b0;
        restart = 1'b0;
        case (q.st)
            RX_IDLE: begin
                if (!q.s2) begin
                    d.st    = RX_START;
                    start_o = 1'b1;
                    restart = 1'b1;
                end
            end
            RX_START: begin
                if (half_evt) begin
                    if (q.s2) begin
                        d.st    = RX_IDLE;
                        abort_o = 1'b1;
                    end else begin
                        d.st    = RX_DATA;
                        d.bitn  = '0;
                        d.phase = 1'b0;
                    end
                end
            end
            default: begin
                if (half_evt) begin
                    d.phase = !q.phase;
                    if (q.phase) begin
                        if (q.bitn == 4'(DATA_W)) begin
                            d.st   = RX_IDLE;
                            done_o = 1'b1;
                        end else begin
                            d.sh   = {q.s2, q.sh[DATA_W-1:1]};
                            d.bitn = q.bitn + 4'd1;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q    <= '0;
            q.s1 <= 1'b1;
            q.s2 <= 1'b1;
            q.st <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st != RX_IDLE);
    assign data_o = q.sh;

    p_start_leaves_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> (q.st == RX_START));
endmodule

// File: rtl/uart_dtr.sv
module uart_dtr
    import uart_dtr_pkg::*;
#(
    parameter int CLK_PER_TICK = 250,
    parameter int HALF_RESET   = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] addr_i,
    input  logic       wr_en_i,
    input  logic       rd_en_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       irq_tx_o,
    output logic       irq_rx_o,
    output logic       txd_o,
    input  logic       rxd_i,
    output logic       rts_o,
    input  logic       cts_i,
    output logic       dtr_o
);
    typedef struct packed {
        logic [HALF_W-1:0] half;
        logic [DATA_W-1:0] rx_data;
        logic              rx_full;
        logic              overrun;
        logic              irq_tx;
        logic              irq_rx;
        logic              dtr;
    } top_regs_t;

    top_regs_t q, d;

    logic tick, wr_data, rd_data;
    logic [HALF_W-1:0] half_eff;
    logic tx_ready, tx_busy, tx_done;
    logic rx_start, rx_abort, rx_done, rx_busy;
    logic [DATA_W-1:0] rx_byte;

    assign wr_data  = wr_en_i && (addr_i == ADDR_DATA);
    assign rd_data  = rd_en_i && (addr_i == ADDR_DATA);
    assign half_eff = (q.half == '0) ? HALF_W'(1) : q.half;

    uart_dtr_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    uart_dtr_tx u_tx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .half_i  (half_eff),
        .load_i  (wr_data),
        .data_i  (wdata_i),
        .cts_i   (cts_i),
        .txd_o   (txd_o),
        .ready_o (tx_ready),
        .busy_o  (tx_busy),
        .done_o  (tx_done)
    );

    uart_dtr_rx u_rx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .half_i  (half_eff),
        .rxd_i   (rxd_i),
        .start_o (rx_start),
        .abort_o (rx_abort),
        .done_o  (rx_done),
        .busy_o  (rx_busy),
        .data_o  (rx_byte)
    );

    always_comb begin
        d = q;
        if (wr_en_i && addr_i == ADDR_HALF) d.half = wdata_i;
        if (wr_data) d.irq_tx = 1'b0;
        if (tx_done) d.irq_tx = 1'b1;
        if (rd_data) begin
            d.rx_full = 1'b0;
            d.irq_rx  = 1'b0;
            d.overrun = 1'b0;
            if (!rx_busy) d.dtr = 1'b1;
        end
        if (rx_start) begin
            d.dtr = 1'b0;
            if (q.rx_full && !rd_data) d.overrun = 1'b1;
        end
        if (rx_abort) d.dtr = !d.rx_full;
        if (rx_done) begin
            d.rx_data = rx_byte;
            d.rx_full = 1'b1;
            d.irq_rx  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.half <= HALF_W'(HALF_RESET);
            q.dtr  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_DATA: rdata_o = q.rx_data;
            ADDR_STAT: begin
                rdata_o[ST_RX_FULL]  = q.rx_full;
                rdata_o[ST_TX_READY] = tx_ready;
                rdata_o[ST_OVERRUN]  = q.overrun;
                rdata_o[ST_IRQ_TX]   = q.irq_tx;
                rdata_o[ST_IRQ_RX]   = q.irq_rx;
            end
            ADDR_HALF: rdata_o = q.half;
            default:   rdata_o = '0;
        endcase
    end

    assign irq_tx_o = q.irq_tx;
    assign irq_rx_o = q.irq_rx;
    assign dtr_o    = q.dtr;
    assign rts_o    = tx_busy || !tx_ready;

    p_dtr_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_start |=> !dtr_o);
    p_dtr_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dtr_o) |-> ($past(rd_data) || $past(rx_abort)));
    p_irq_rx_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_done |=> (irq_rx_o && q.rx_full));
    p_irq_tx_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_done |=> irq_tx_o);
    p_overrun_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_start && q.rx_full && !rd_data) |=> q.overrun);
    p_glitch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_abort && !q.rx_full) |=> dtr_o);
endmodule

// File: tb/uart_dtr_tb.sv
module uart_dtr_tb;
    localparam int CPT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_tx, irq_rx, txd, rts, dtr;
    logic       rxd = 1'b1;
    logic       cts = 1'b0;

    int total = 0;
    int bad = 0;
    int bit_cyc = 2 * 4 * CPT;
    int frames = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];

    always #2 clk = !clk;

    uart_dtr #(.CLK_PER_TICK(CPT), .HALF_RESET(4)) u_dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .addr_i   (addr),
        .wr_en_i  (wr_en),
        .rd_en_i  (rd_en),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .irq_tx_o (irq_tx),
        .irq_rx_o (irq_rx),
        .txd_o    (txd),
        .rxd_i    (rxd),
        .rts_o    (rts),
        .cts_i    (cts),
        .dtr_o    (dtr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send_tx(input logic [7:0] b);
        exp_tx.push_back(b);
        cpu_write(2'd0, b);
    endtask

    task automatic wait_tx_done();
        for (int k = 0; k < 5000 && !irq_tx; k++) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b);
        exp_rx.push_back(b);
        @(negedge clk);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        chk("R3 dtr low after start", dtr, 1'b0);
        repeat (bit_cyc - 6) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bit_cyc) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (bit_cyc) @(negedge clk);
    endtask

    task automatic read_rx_byte(input string req);
        logic [7:0] v, e;
        cpu_read(2'd0, v);
        e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 8'hxx;
        chk(req, v, e);
    endtask

    task automatic measure_bit(output int n);
        n = 0;
        @(negedge txd);
        @(posedge txd);
        while (txd) begin
            @(posedge clk);
            #1;
            n++;
        end
    endtask

    // Scoreboard monitor: decodes each TXD frame and compares against the queue (R1)
    initial begin
        logic [7:0] b;
        logic [7:0] e;
        wait (rst_n);
        forever begin
            @(negedge txd);
            repeat (bit_cyc / 2) @(posedge clk);
            #1 chk("R1 start bit", txd, 1'b0);
            for (int i = 0; i < 8; i++) begin
                repeat (bit_cyc) @(posedge clk);
                #1 b[i] = txd;
            end
            repeat (bit_cyc) @(posedge clk);
            #1 chk("R1 stop bit", txd, 1'b1);
            e = (exp_tx.size() > 0) ? exp_tx.pop_front() : 8'hxx;
            chk("R1 frame byte", b, e);
            frames++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n, f0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 txd", txd, 1'b1);
        chk("R9 dtr", dtr, 1'b1);
        chk("R9 rts", rts, 1'b0);
        chk("R9 irq_tx", irq_tx, 1'b0);
        chk("R9 irq_rx", irq_rx, 1'b0);
        cpu_read(2'd2, v);
        chk("R9 half reset", v, 8'd4);
        cpu_read(2'd1, v);
        chk("R9 status", v, 8'h02);

        cts = 1'b1;
        send_tx(8'hA5);
        wait_tx_done();
        chk("R7 irq_tx after frame", irq_tx, 1'b1);
        cpu_read(2'd1, v);
        chk("R7 status bit3", v[3], 1'b1);
        send_tx(8'h55);
        chk("R7 irq_tx cleared by write", irq_tx, 1'b0);
        measure_bit(n);
        chk("R2 bit width half=4", n, 2 * 4 * CPT);
        wait_tx_done();

        cpu_write(2'd2, 8'd0);
        bit_cyc = 2 * CPT;
        cpu_read(2'd2, v);
        chk("R2 half readback zero", v, 8'd0);
        send_tx(8'h55);
        measure_bit(n);
        chk("R2 bit width half=0", n, 2 * CPT);
        wait_tx_done();
        cpu_write(2'd2, 8'd4);
        bit_cyc = 2 * 4 * CPT;

        // R6: held by CTS
        cts = 1'b0;
        f0 = frames;
        send_tx(8'h3C);
        repeat (400) @(negedge clk);
        chk("R6 txd idle while cts low", txd, 1'b1);
        chk("R6 rts while waiting", rts, 1'b1);
        chk("R6 no frame while cts low", frames, f0);
        cts = 1'b1;
        wait_tx_done();
        repeat (4) @(negedge clk);
        chk("R6 frame after cts", frames, f0 + 1);
        chk("R6 rts released", rts, 1'b0);

        // R3/R4/R5 receive path
        send_rx(8'h3C);
        repeat (10) @(negedge clk);
        chk("R4 dtr held low until read", dtr, 1'b0);
        chk("R5 irq_rx", irq_rx, 1'b1);
        cpu_read(2'd1, v);
        chk("R5 status", v & 8'hF7, 8'h13);
        cpu_read(2'd1, v);
        chk("R5 status read clears nothing", v & 8'hF7, 8'h13);
        read_rx_byte("R5 data byte");
        @(negedge clk);
        chk("R5 irq_rx cleared", irq_rx, 1'b0);
        chk("R4 dtr after read", dtr, 1'b1);

        send_rx(8'hC3);
        repeat (10) @(negedge clk);
        read_rx_byte("R5 second byte");

        // R8 overrun
        send_rx(8'h11);
        send_rx(8'h22);
        exp_rx.delete();
        exp_rx.push_back(8'h22);
        repeat (10) @(negedge clk);
        chk("R8 dtr low through overrun", dtr, 1'b0);
        cpu_read(2'd1, v);
        chk("R8 overrun flag", v[2], 1'b1);
        read_rx_byte("R8 newer byte kept");
        cpu_read(2'd1, v);
        chk("R8 overrun cleared", v[2], 1'b0);

        // R10 short glitch
        @(negedge clk);
        rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (100) @(negedge clk);
        chk("R10 dtr restored", dtr, 1'b1);
        chk("R10 no irq_rx", irq_rx, 1'b0);
        cpu_read(2'd1, v);
        chk("R10 no byte waiting", v[0], 1'b0);

        repeat (20) @(negedge clk);
        chk("R1 all frames seen", exp_tx.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule